// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block is a small, fully associative translation cache that sits in front of a single memory access port. An instruction fetch port and a data port each get their own copy. A parameter selects the variant. The requester presents a virtual address together with its ASID, security state, privilege level and access direction. In that same cycle the block answers with a hit flag, the physical address for the cache tag compare, the memory attributes and a permission verdict. When a fault is found, the block raises the abort flavour that belongs to its port.

On a miss the block stalls the requester and opens a request to a shared second-level translation cache. The request carries the page address, ASID and security state. When the response arrives, the block writes it into an entry. The chosen entry is the lowest-numbered empty slot, or else the slot under a round-robin pointer. The requester, which keeps its request stable, then hits on the next cycle.

A flush input empties the whole array in one step. The surrounding logic drives it when second-level maintenance runs and when a write lands on any context, domain, memory remap or table base control register.

Top module: `utlb_front`

## Requirements
- R1: After reset, no entry is valid and `fill_req` is low. Every lookup misses, with `hit` low and `stall` high while `req_valid` is high.
- R2: A lookup that matches an entry asserts `hit` combinationally in the same cycle as `req_valid`, with `stall` low. It drives `pa` and `attr` from that entry.
- R3: `fill_size` codes page sizes as 0 = 4 KB, 1 = 64 KB, 2 = 1 MB and 3 = 16 MB. Only the virtual address bits above the page offset are compared. `pa` takes those bits from the entry and the offset bits from `req_va`.
- R4: An entry hits only when its `req_ns` state matches the request and either its ASID equals `req_asid` or its global bit is set.
- R5: A miss seen at a clock edge while no fill is open raises `fill_req` from the next cycle. `fill_req` carries `fill_req_va` (page bits, low 12 bits zero), `fill_req_asid` and `fill_req_ns`, and stays high until `fill_valid`.
- R6: On `fill_valid` the response is written as a valid entry, using the captured page, ASID and security state. The held request hits in the following cycle.
- R7: On the data variant (`IS_FETCH`=0), `fill_ap` codes access as 0 = no access, 1 = privileged only, 2 = full, 3 = read-only. A user access to code 1, any access to code 0, and a write to code 3 raise `dabort`. The execute-never bit has no effect.
- R8: On the fetch variant (`IS_FETCH`=1), an execute-never page, code 0, or a user access to code 1 raises `pabort`. `req_write` has no effect, and `dabort` never rises.
- R9: `flush` invalidates every entry at the clock edge, so lookups miss from the next cycle. A fill response arriving in a flush cycle closes the open request but is not written.
- R10: When an empty slot exists, the lowest-numbered one is filled. Otherwise the round-robin pointer chooses the slot. The pointer advances by one, wrapping, on every write, and is reset to slot 0 by flush and by reset.
- R11: An abort is raised only together with `hit`. A missing lookup raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate the whole array |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address space identifier |
| req_ns | input | 1 | Request security state (1 = non-secure) |
| req_user | input | 1 | Unprivileged access |
| req_write | input | 1 | Write access (data variant only) |
| hit | output | 1 | Lookup matched an entry |
| stall | output | 1 | Request present but not translated |
| pa | output | 32 | Physical address |
| attr | output | 4 | Memory attributes of the matching entry |
| pabort | output | 1 | Permission fault on the fetch variant |
| dabort | output | 1 | Permission fault on the data variant |
| fill_req | output | 1 | Open request to the second-level cache |
| fill_req_va | output | 32 | Page address of the missing request |
| fill_req_asid | output | 8 | ASID of the missing request |
| fill_req_ns | output | 1 | Security state of the missing request |
| fill_valid | input | 1 | Second-level response present |
| fill_ppn | input | 20 | Physical page bits of the response |
| fill_size | input | 2 | Page size code of the response |
| fill_global | input | 1 | Response entry is global |
| fill_ap | input | 2 | Access permission code |
| fill_xn | input | 1 | Execute-never bit |
| fill_attr | input | 4 | Memory attributes |

## Verification
The hardest situation to reach from the ports is round-robin eviction. It happens only after every one of the ten slots holds a valid page. The stimulus therefore flushes the array, so that the pointer returns to slot 0, and then fills ten distinct pages. An eleventh fill must evict the first page. A twelfth fill must evict the second page, which shows the pointer stepping. A second hard case is a response that lands in the same cycle as a flush: the bench launches a miss and drives the response and the flush together, then checks that the request closed and that nothing was written.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
package utlb_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int ASID_W   = 8;
    localparam int ATTR_W   = 4;
    localparam int SH_64K   = 4;
    localparam int SH_1M    = 8;
    localparam int SH_16M   = 12;

    typedef enum logic [1:0] {PG_4K, PG_64K, PG_1M, PG_16M} pg_size_e;
    typedef enum logic [1:0] {AP_NONE, AP_PRIV, AP_FULL, AP_RO} ap_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        pg_size_e          size;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              nsid;
        ap_e               ap;
        logic              xn;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    // Page-number bits that take part in the compare for a given size
    function automatic logic [VPN_W-1:0] pg_mask(input pg_size_e s);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (s)
            PG_64K:  pg_mask = ones << SH_64K;
            PG_1M:   pg_mask = ones << SH_1M;
            PG_16M:  pg_mask = ones << SH_16M;
            default: pg_mask = ones;
        endcase
    endfunction
endpackage

// File: rtl/utlb_match.sv
`timescale 1ns/1ps
module utlb_match
    import utlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic              ns,
    output logic              hit,
    output logic [VPN_W-1:0]  ppn_out
);
    logic [VPN_W-1:0] mask;

    always_comb begin
        mask    = pg_mask(ent.size);
        hit     = ent.valid
                  && (((ent.vpn ^ vpn) & mask) == '0)
                  && (ent.nsid == ns)
                  && (ent.glob || (ent.asid == asid));
        ppn_out = (ent.ppn & mask) | (vpn & ~mask);
    end
endmodule

// File: rtl/utlb_victim.sv
`timescale 1ns/1ps
module utlb_victim #(
    parameter int N  = 10,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/utlb_perm.sv
`timescale 1ns/1ps
module utlb_perm
    import utlb_pkg::*;
#(
    parameter bit IS_FETCH = 1'b0
) (
    input  logic [1:0] ap,
    input  logic       xn,
    input  logic       user,
    input  logic       write,
    output logic       fault
);
    logic base_fault;
    assign base_fault = (ap == AP_NONE) || ((ap == AP_PRIV) && user);

    generate
        if (IS_FETCH) begin : g_fetch
            logic unused_wr;
            assign unused_wr = write;
            assign fault     = base_fault || xn;
        end else begin : g_data
            logic unused_xn;
            assign unused_xn = xn;
            assign fault     = base_fault || ((ap == AP_RO) && write);
        end
    endgenerate
endmodule

// File: rtl/utlb_front.sv
`timescale 1ns/1ps
module utlb_front
    import utlb_pkg::*;
#(
    parameter int N_ENTRIES = 10,
    parameter bit IS_FETCH  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_ns,
    input  logic              req_user,
    input  logic              req_write,
    output logic              hit,
    output logic              stall,
    output logic [VA_W-1:0]   pa,
    output logic [ATTR_W-1:0] attr,
    output logic              pabort,
    output logic              dabort,
    output logic              fill_req,
    output logic [VA_W-1:0]   fill_req_va,
    output logic [ASID_W-1:0] fill_req_asid,
    output logic              fill_req_ns,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_ppn,
    input  logic [1:0]        fill_size,
    input  logic              fill_global,
    input  logic [1:0]        fill_ap,
    input  logic              fill_xn,
    input  logic [ATTR_W-1:0] fill_attr
);
    localparam int IW = $clog2(N_ENTRIES);

    typedef struct packed {
        tlb_ent_t [N_ENTRIES-1:0] ents;
        logic [IW-1:0]            ptr;
        logic                     wait_fill;
        logic [VPN_W-1:0]         mvpn;
        logic [ASID_W-1:0]        masid;
        logic                     mns;
    } st_t;

    st_t st_d, st_q;

    logic [N_ENTRIES-1:0]            match_vec;
    logic [N_ENTRIES-1:0]            vld_vec;
    logic [N_ENTRIES-1:0][VPN_W-1:0] ppn_vec;
    logic [VPN_W-1:0]                sel_ppn;
    logic [1:0]                      sel_ap;
    logic                            sel_xn;
    logic [ATTR_W-1:0]               sel_attr;
    logic [IW-1:0]                   vic_idx;
    logic                            fault;

    // One comparator per entry
    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
            utlb_match u_match (
                .ent     (st_q.ents[g]),
                .vpn     (req_va[VA_W-1:OFF_W]),
                .asid    (req_asid),
                .ns      (req_ns),
                .hit     (match_vec[g]),
                .ppn_out (ppn_vec[g])
            );
            assign vld_vec[g] = st_q.ents[g].valid;
        end
    endgenerate

    utlb_victim #(.N(N_ENTRIES), .IW(IW)) u_victim (
        .vld (vld_vec),
        .ptr (st_q.ptr),
        .idx (vic_idx)
    );

    // Software keeps matches unique, so an OR-mux selects the winner
    always_comb begin
        sel_ppn  = '0;
        sel_ap   = '0;
        sel_xn   = 1'b0;
        sel_attr = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            sel_ppn  |= ppn_vec[i] & {VPN_W{match_vec[i]}};
            sel_ap   |= st_q.ents[i].ap & {2{match_vec[i]}};
            sel_xn   |= st_q.ents[i].xn & match_vec[i];
            sel_attr |= st_q.ents[i].attr & {ATTR_W{match_vec[i]}};
        end
    end

    utlb_perm #(.IS_FETCH(IS_FETCH)) u_perm (
        .ap    (sel_ap),
        .xn    (sel_xn),
        .user  (req_user),
        .write (req_write),
        .fault (fault)
    );

    assign hit   = req_valid && (|match_vec);
    assign stall = req_valid && !hit;
    assign pa    = {sel_ppn, req_va[OFF_W-1:0]};
    assign attr  = sel_attr;

    generate
        if (IS_FETCH) begin : g_iab
            assign pabort = hit && fault;
            assign dabort = 1'b0;
        end else begin : g_dab
            assign pabort = 1'b0;
            assign dabort = hit && fault;
        end
    endgenerate

    assign fill_req      = st_q.wait_fill;
    assign fill_req_va   = {st_q.mvpn, {OFF_W{1'b0}}};
    assign fill_req_asid = st_q.masid;
    assign fill_req_ns   = st_q.mns;

    always_comb begin
        st_d = st_q;
        if (st_q.wait_fill && fill_valid) begin
            st_d.wait_fill = 1'b0;
            if (!flush) begin
                st_d.ents[vic_idx].valid = 1'b1;
                st_d.ents[vic_idx].vpn   = st_q.mvpn;
                st_d.ents[vic_idx].ppn   = fill_ppn;
                st_d.ents[vic_idx].size  = pg_size_e'(fill_size);
                st_d.ents[vic_idx].asid  = st_q.masid;
                st_d.ents[vic_idx].glob  = fill_global;
                st_d.ents[vic_idx].nsid  = st_q.mns;
                st_d.ents[vic_idx].ap    = ap_e'(fill_ap);
                st_d.ents[vic_idx].xn    = fill_xn;
                st_d.ents[vic_idx].attr  = fill_attr;
                st_d.ptr = (st_q.ptr == IW'(N_ENTRIES - 1)) ? '0 : st_q.ptr + IW'(1);
            end
        end else if (!st_q.wait_fill && stall && !flush) begin
            st_d.wait_fill = 1'b1;
            st_d.mvpn      = req_va[VA_W-1:OFF_W];
            st_d.masid     = req_asid;
            st_d.mns       = req_ns;
        end
        if (flush) begin
            for (int i = 0; i < N_ENTRIES; i++) st_d.ents[i].valid = 1'b0;
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/utlb_front_chk.sv
`timescale 1ns/1ps
module utlb_front_chk
    import utlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic [ASID_W-1:0] req_asid,
    input logic              req_ns,
    input logic              hit,
    input logic              pabort,
    input logic              dabort,
    input logic              fill_req,
    input logic [VA_W-1:0]   fill_req_va,
    input logic [ASID_W-1:0] fill_req_asid,
    input logic              fill_req_ns,
    input logic              fill_valid
);
    p_miss_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && !fill_req && !flush) |=> fill_req);

    p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> fill_req);

    p_fill_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid && !flush) ##1
        (req_valid && req_va[VA_W-1:OFF_W] == $past(fill_req_va[VA_W-1:OFF_W])
         && req_asid == $past(fill_req_asid) && req_ns == $past(fill_req_ns))
        |-> hit);

    p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

    p_abort_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pabort || dabort) |-> hit);

    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pabort && dabort));
endmodule

bind utlb_front utlb_front_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .req_asid      (req_asid),
    .req_ns        (req_ns),
    .hit           (hit),
    .pabort        (pabort),
    .dabort        (dabort),
    .fill_req      (fill_req),
    .fill_req_va   (fill_req_va),
    .fill_req_asid (fill_req_asid),
    .fill_req_ns   (fill_req_ns),
    .fill_valid    (fill_valid)
);

// File: tb/test_utlb_front.sv
`timescale 1ns/1ps
module test_utlb_front;
    import utlb_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, req_valid = 1'b0, sel_if = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic req_ns = 1'b0, req_user = 1'b0, req_write = 1'b0, fill_valid = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0, fill_ap = '0;
    logic fill_global = 1'b0, fill_xn = 1'b0;
    logic [3:0]  fill_attr = '0;

    logic d_hit, d_stall, d_pab, d_dab, d_freq, d_fns;
    logic i_hit, i_stall, i_pab, i_dab, i_freq, i_fns;
    logic [31:0] d_pa, i_pa, d_fva, i_fva;
    logic [3:0]  d_attr, i_attr;
    logic [7:0]  d_fasid, i_fasid;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    utlb_front #(.N_ENTRIES(10), .IS_FETCH(1'b0)) i_utlb_front (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid && !sel_if),
        .req_va(req_va), .req_asid(req_asid), .req_ns(req_ns), .req_user(req_user),
        .req_write(req_write), .hit(d_hit), .stall(d_stall), .pa(d_pa), .attr(d_attr),
        .pabort(d_pab), .dabort(d_dab), .fill_req(d_freq), .fill_req_va(d_fva),
        .fill_req_asid(d_fasid), .fill_req_ns(d_fns), .fill_valid(fill_valid && !sel_if),
        .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_global(fill_global),
        .fill_ap(fill_ap), .fill_xn(fill_xn), .fill_attr(fill_attr));

    utlb_front #(.N_ENTRIES(10), .IS_FETCH(1'b1)) i_utlb_front_if (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid && sel_if),
        .req_va(req_va), .req_asid(req_asid), .req_ns(req_ns), .req_user(req_user),
        .req_write(req_write), .hit(i_hit), .stall(i_stall), .pa(i_pa), .attr(i_attr),
        .pabort(i_pab), .dabort(i_dab), .fill_req(i_freq), .fill_req_va(i_fva),
        .fill_req_asid(i_fasid), .fill_req_ns(i_fns), .fill_valid(fill_valid && sel_if),
        .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_global(fill_global),
        .fill_ap(fill_ap), .fill_xn(fill_xn), .fill_attr(fill_attr));

    wire        m_hit   = sel_if ? i_hit   : d_hit;
    wire        m_stall = sel_if ? i_stall : d_stall;
    wire [31:0] m_pa    = sel_if ? i_pa    : d_pa;
    wire [3:0]  m_attr  = sel_if ? i_attr  : d_attr;
    wire        m_pab   = sel_if ? i_pab   : d_pab;
    wire        m_dab   = sel_if ? i_dab   : d_dab;
    wire        m_freq  = sel_if ? i_freq  : d_freq;
    wire [31:0] m_fva   = sel_if ? i_fva   : d_fva;
    wire [7:0]  m_fasid = sel_if ? i_fasid : d_fasid;
    wire        m_fns   = sel_if ? i_fns   : d_fns;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  attr;
        logic        pab;
        logic        dab;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    // Monitor: compares the combinational answer mid-cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [39:0] act, exp;
            e = sb.pop_front();
            act = {m_hit, m_stall, m_pab, m_dab, (e.hit ? {m_pa, m_attr} : 36'h0)};
            exp = {e.hit, !e.hit, e.pab, e.dab, (e.hit ? {e.pa, e.attr} : 36'h0)};
            chk(act == exp, e.tag, 64'(act), 64'(exp));
        end
    end

    task automatic look(input logic [31:0] va, input logic [7:0] a, input logic n,
                        input logic u, input logic w, input logic eh, input logic [31:0] epa,
                        input logic [3:0] eat, input logic epab, input logic edab, input string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = va; req_asid = a; req_ns = n; req_user = u; req_write = w;
        sb.push_back('{eh, epa, eat, epab, edab, tag});
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic [7:0] a, input logic n,
                        input logic [1:0] sz, input logic [19:0] ppn, input logic g,
                        input logic [1:0] ap, input logic xn, input logic [3:0] at,
                        input bit extra);
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = va; req_asid = a; req_ns = n; req_user = 1'b0; req_write = 1'b0;
        @(posedge clk); #1;
        chk(m_freq && m_fva == {va[31:12], 12'h0} && m_fasid == a && m_fns == n,
            "R5 fill request fields", {m_freq, m_fva, m_fasid, m_fns}, {1'b1, va[31:12], 12'h0, a, n});
        if (extra) begin
            @(posedge clk); #1;
            chk(m_freq, "R5 fill request held", 64'(m_freq), 64'(1));
        end
        fill_valid = 1'b1; fill_ppn = ppn; fill_size = sz; fill_global = g;
        fill_ap = ap; fill_xn = xn; fill_attr = at;
        @(posedge clk); #1;
        fill_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    localparam logic [7:0] AS_A = 8'h11, AS_B = 8'h22;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!d_freq && !i_freq, "R1 no fill request in reset", {d_freq, i_freq}, 0);
        rst_n = 1'b1;
        look(32'h1000_0000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R1 empty array misses");
        @(posedge clk); #1;
        chk(!d_freq, "R1 no fill without edge miss", 64'(d_freq), 0);

        // Data side: page sizes and qualifiers
        fill(32'h0040_3ABC, AS_A, 0, 2'd0, 20'h81234, 0, 2'd2, 0, 4'h5, 1);
        look(32'h0040_3ABC, AS_A, 0, 0, 0, 1, 32'h8123_4ABC, 4'h5, 0, 0, "R6 R2 hit after fill");
        look(32'h0040_3FFF, AS_A, 0, 0, 0, 1, 32'h8123_4FFF, 4'h5, 0, 0, "R3 4KB offset");
        look(32'h0040_4000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R3 next 4KB page misses");
        look(32'h0040_3ABC, AS_B, 0, 0, 0, 0, 0, 0, 0, 0, "R4 ASID mismatch misses");
        look(32'h0040_3ABC, AS_A, 1, 0, 0, 0, 0, 0, 0, 0, "R4 security mismatch misses");
        fill(32'h1234_5678, AS_A, 0, 2'd1, 20'hABCD0, 0, 2'd2, 0, 4'h3, 0);
        look(32'h1234_F00C, AS_A, 0, 0, 0, 1, 32'hABCD_F00C, 4'h3, 0, 0, "R3 64KB passthrough");
        look(32'h1235_0000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R3 outside 64KB misses");
        fill(32'h3000_0000, AS_A, 0, 2'd2, 20'h45600, 1, 2'd2, 0, 4'h9, 0);
        look(32'h300A_BCDE, AS_B, 0, 0, 0, 1, 32'h456A_BCDE, 4'h9, 0, 0, "R4 R3 global 1MB any ASID");
        look(32'h3100_0000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R3 outside 1MB misses");
        fill(32'h5000_0000, AS_A, 1, 2'd3, 20'h7F000, 0, 2'd2, 0, 4'h1, 0);
        look(32'h50FF_1234, AS_A, 1, 0, 0, 1, 32'h7FFF_1234, 4'h1, 0, 0, "R3 16MB non-secure hit");
        look(32'h50FF_1234, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R4 secure request misses ns entry");

        // Data side permissions
        fill(32'h0060_0000, AS_A, 0, 2'd0, 20'h00111, 0, 2'd1, 0, 4'h2, 0);
        look(32'h0060_0010, AS_A, 0, 1, 0, 1, 32'h0011_1010, 4'h2, 0, 1, "R7 user on privileged page");
        look(32'h0060_0010, AS_A, 0, 0, 1, 1, 32'h0011_1010, 4'h2, 0, 0, "R7 privileged write allowed");
        fill(32'h0061_0000, AS_A, 0, 2'd0, 20'h00222, 0, 2'd3, 1, 4'h2, 0);
        look(32'h0061_0004, AS_A, 0, 1, 0, 1, 32'h0022_2004, 4'h2, 0, 0, "R7 read-only read, xn no effect");
        look(32'h0061_0004, AS_A, 0, 0, 1, 1, 32'h0022_2004, 4'h2, 0, 1, "R7 write to read-only");
        fill(32'h0062_0000, AS_A, 0, 2'd0, 20'h00333, 0, 2'd0, 0, 4'h2, 0);
        look(32'h0062_0000, AS_A, 0, 0, 0, 1, 32'h0033_3000, 4'h2, 0, 1, "R7 no-access page");
        look(32'h0063_0000, AS_A, 0, 1, 1, 0, 0, 0, 0, 0, "R11 miss raises no abort");

        // Fetch side
        @(posedge clk); #1; sel_if = 1'b1;
        fill(32'h0800_0000, AS_A, 0, 2'd0, 20'h0A000, 0, 2'd2, 1, 4'h6, 0);
        look(32'h0800_0040, AS_A, 0, 0, 0, 1, 32'h0A00_0040, 4'h6, 1, 0, "R8 execute-never fetch");
        fill(32'h0801_0000, AS_A, 0, 2'd0, 20'h0B000, 0, 2'd3, 0, 4'h6, 0);
        look(32'h0801_0000, AS_A, 0, 0, 1, 1, 32'h0B00_0000, 4'h6, 0, 0, "R8 write ignored on fetch");
        fill(32'h0802_0000, AS_A, 0, 2'd0, 20'h0C000, 0, 2'd1, 0, 4'h6, 0);
        look(32'h0802_0000, AS_A, 0, 1, 0, 1, 32'h0C00_0000, 4'h6, 1, 0, "R8 user fetch privileged page");
        look(32'h0802_0000, AS_A, 0, 0, 0, 1, 32'h0C00_0000, 4'h6, 0, 0, "R8 privileged fetch ok");
        @(posedge clk); #1; sel_if = 1'b0;

        // Flush
        @(posedge clk); #1; flush = 1'b1;
        @(posedge clk); #1; flush = 1'b0;
        look(32'h0040_3ABC, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R9 flushed 4KB entry misses");
        look(32'h300A_BCDE, AS_B, 0, 0, 0, 0, 0, 0, 0, 0, "R9 flushed global entry misses");

        // Response in a flush cycle is dropped
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = 32'h0040_3ABC; req_asid = AS_A; req_ns = 0; req_user = 0; req_write = 0;
        @(posedge clk); #1;
        chk(d_freq, "R5 miss opens request", 64'(d_freq), 64'(1));
        fill_valid = 1'b1; flush = 1'b1; fill_ppn = 20'h81234; fill_size = 0; fill_ap = 2'd2;
        @(posedge clk); #1;
        fill_valid = 1'b0; flush = 1'b0; req_valid = 1'b0;
        chk(!d_freq, "R9 request closed by flush-cycle response", 64'(d_freq), 0);
        look(32'h0040_3ABC, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R9 flush-cycle response not written");

        // Replacement: ten pages, then two evictions
        for (int i = 0; i < 11; i++)
            fill(32'h0100_0000 + (i << 12), AS_A, 0, 2'd0, 20'h20000 + 20'(i), 0, 2'd2, 0, 4'h7, 0);
        look(32'h0100_0000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R10 first page evicted by eleventh fill");
        look(32'h0100_1008, AS_A, 0, 0, 0, 1, 32'h2000_1008, 4'h7, 0, 0, "R10 second page kept");
        look(32'h0100_A000, AS_A, 0, 0, 0, 1, 32'h2000_A000, 4'h7, 0, 0, "R10 eleventh page present");
        fill(32'h0100_0000, AS_A, 0, 2'd0, 20'h20000, 0, 2'd2, 0, 4'h7, 0);
        look(32'h0100_1000, AS_A, 0, 0, 0, 0, 0, 0, 0, 0, "R10 pointer stepped to second slot");
        look(32'h0100_2000, AS_A, 0, 0, 0, 1, 32'h2000_2000, 4'h7, 0, 0, "R10 third page kept");
        look(32'h0100_0000, AS_A, 0, 0, 0, 1, 32'h2000_0000, 4'h7, 0, 0, "R6 refilled page hits");

        repeat (4) @(posedge clk);
        chk(sb.size() == 0, "scoreboard drained", 64'(sb.size()), 0);
        finish_run();
    end
endmodule